// File: doc/BRIEF.md
# Interleaved Slot Unpacker

This block feeds a small stack-machine decoder from a 20-bit instruction word that packs four 5-bit opcodes. The opcode bits are spread across the word: bit j of slot k sits at word position 4*j + k. Every other slot is also stored complemented. With this layout, stepping from one slot to the next takes a one-position right shift of a holding register. A fixed tap at positions 0, 4, 8, 12 and 16 then always yields the current slot. Per-slot inversion masks, derived from a mask parameter, restore the true opcode value.

A word is loaded through a valid/ready handshake. One opcode per cycle is then presented with a valid strobe and its slot index, unless the hold input freezes the sequence. When the literal opcode is found, decoding of that word stops. The bits above the consumed slot come out as a data value to push, flagged by a separate strobe. After the fourth slot or a literal, the block asks for the next word. It can accept that word in the same cycle, so words can follow each other with no gap.

Top module: `ilv_slot_unpacker`

## Requirements
- R1: While reset is applied and right after it, op_valid and lit_valid are low and word_ready is high.
- R2: A word is taken on a clock edge where word_valid and word_ready are both high, and slot 0 of that word is presented (op_valid high, op_slot 0) in the next cycle unless hold is high.
- R3: Bit j of the opcode for slot k equals word_data[4*j+k] XOR INV_MASK[4*j+k]; with the default mask 20'hAAAAA, slots 1 and 3 come out inverted and slots 0 and 2 as stored.
- R4: With hold low, slots are presented in the order 0, 1, 2, 3, one per cycle, each with op_slot equal to its index.
- R5: While hold is high, op_valid is low and the current slot is kept; it is presented once hold falls, and no slot is skipped.
- R6: When the presented opcode equals LIT_OP (default 5'd9) in slot k, lit_valid is high in that cycle and lit_data equals the loaded word shifted right by k+1 positions, zero-filled; no later slot of that word is presented.
- R7: word_ready is high while no word is held, and high in the cycle that presents slot 3 or a literal; in any other cycle while a word is held, it is low.
- R8: After the last slot of a word, op_valid and lit_valid stay low until a new word is taken.
- R9: lit_valid is high only together with op_valid and an opcode equal to LIT_OP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| word_valid | input | 1 | A new instruction word is offered |
| word_data | input | 20 | Interleaved instruction word |
| word_ready | output | 1 | Request for the next word; a load happens when it and word_valid are high |
| hold | input | 1 | Freezes the current slot; no opcode is presented |
| op_valid | output | 1 | An opcode is presented this cycle |
| op_code | output | 5 | Restored opcode of the current slot |
| op_slot | output | 2 | Index of the current slot |
| lit_valid | output | 1 | The current opcode is a literal and lit_data holds its payload |
| lit_data | output | 20 | Zero-extended literal payload |

## Verification
The assertions assume that inputs are known after reset. They also assume that a load happens only while word_ready is high, which the handshake itself enforces. They make no demand that word_valid stay up or that word_data stay stable. The stimulus changes inputs only on the falling clock edge and waits a few cycles after reset so the internal synchronizer has released. It offers a word either while the block is idle or in the same cycle as the final slot, so both the gapped and back-to-back load paths are covered. Every opcode value is placed in every slot. Hold is raised at different slot positions within a word.

// File: rtl/slotunp_pkg.sv
package slotunp_pkg;

  // Position of bit bit_idx of slot slot_idx inside the packed word.
  function automatic int lane_pos(input int bit_idx, input int slot_idx, input int slots);
    return bit_idx * slots + slot_idx;
  endfunction

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } seq_state_e;

endpackage

// File: rtl/slotunp_rst_sync.sv
module slotunp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_q
);

  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q  <= 1'b0;
      rst_n_q <= 1'b0;
    end else begin
      meta_q  <= 1'b1;
      rst_n_q <= meta_q;
    end
  end

endmodule

// File: rtl/slotunp_tap.sv
module slotunp_tap
  import slotunp_pkg::*;
#(
  parameter int                         SLOTS    = 4,
  parameter int                         OP_W     = 5,
  parameter logic [SLOTS*OP_W-1:0]      INV_MASK = 20'hAAAAA,
  parameter logic [OP_W-1:0]            LIT_OP   = 5'd9,
  localparam int                        WORD_W   = SLOTS * OP_W,
  localparam int                        CNT_W    = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic [WORD_W-1:0] sreg_i,
  input  logic [CNT_W-1:0]  slot_i,
  output logic [OP_W-1:0]   op_o,
  output logic              is_lit_o,
  output logic [WORD_W-1:0] payload_o
);

  logic [OP_W-1:0]            raw_taps;
  logic [SLOTS-1:0][OP_W-1:0] slot_mask;

  // Fixed taps: the current slot always sits in lane 0 of the register.
  for (genvar gj = 0; gj < OP_W; gj++) begin : g_tap
    assign raw_taps[gj] = sreg_i[lane_pos(gj, 0, SLOTS)];
  end

  // Per-slot inversion pattern pulled out of the word-wide mask.
  for (genvar gk = 0; gk < SLOTS; gk++) begin : g_slot
    for (genvar gj = 0; gj < OP_W; gj++) begin : g_bit
      assign slot_mask[gk][gj] = INV_MASK[lane_pos(gj, gk, SLOTS)];
    end
  end

  always_comb begin
    op_o      = raw_taps ^ slot_mask[slot_i];
    is_lit_o  = (op_o == LIT_OP);
    payload_o = {1'b0, sreg_i[WORD_W-1:1]};
  end

endmodule

// File: rtl/slotunp_seq.sv
module slotunp_seq
  import slotunp_pkg::*;
#(
  parameter int  SLOTS  = 4,
  parameter int  OP_W   = 5,
  localparam int WORD_W = SLOTS * OP_W,
  localparam int CNT_W  = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              step_i,
  input  logic              finish_i,
  output logic [WORD_W-1:0] sreg_o,
  output logic [CNT_W-1:0]  slot_o,
  output logic              busy_o
);

  seq_state_e        state_q, state_n;
  logic [CNT_W-1:0]  slot_q,  slot_n;
  logic [WORD_W-1:0] sreg_q,  sreg_n;
  logic              sreg_en;

  // Next-state logic: a load wins over the end of the previous word.
  always_comb begin
    state_n = state_q;
    slot_n  = slot_q;
    sreg_n  = sreg_q;
    sreg_en = 1'b0;
    if (step_i) begin
      if (finish_i) begin
        state_n = ST_IDLE;
      end else begin
        slot_n  = slot_q + CNT_W'(1);
        sreg_n  = sreg_q >> 1;
        sreg_en = 1'b1;
      end
    end
    if (load_i) begin
      state_n = ST_RUN;
      slot_n  = '0;
      sreg_n  = word_i;
      sreg_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      slot_q  <= '0;
    end else begin
      state_q <= state_n;
      slot_q  <= slot_n;
    end
  end

  // Data register: no reset, written only through its enable.
  always_ff @(posedge clk) begin
    if (sreg_en) begin
      sreg_q <= sreg_n;
    end
  end

  assign sreg_o = sreg_q;
  assign slot_o = slot_q;
  assign busy_o = (state_q == ST_RUN);

endmodule

// File: rtl/ilv_slot_unpacker.sv
module ilv_slot_unpacker #(
  parameter int                    SLOTS    = 4,
  parameter int                    OP_W     = 5,
  parameter logic [SLOTS*OP_W-1:0] INV_MASK = 20'hAAAAA,
  parameter logic [OP_W-1:0]       LIT_OP   = 5'd9,
  localparam int                   WORD_W   = SLOTS * OP_W,
  localparam int                   CNT_W    = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_valid,
  input  logic [WORD_W-1:0] word_data,
  output logic              word_ready,
  input  logic              hold,
  output logic              op_valid,
  output logic [OP_W-1:0]   op_code,
  output logic [CNT_W-1:0]  op_slot,
  output logic              lit_valid,
  output logic [WORD_W-1:0] lit_data
);

  localparam logic [CNT_W-1:0] LAST_SLOT = CNT_W'(SLOTS - 1);

  logic              rst_n_q;
  logic              busy;
  logic              step;
  logic              finish;
  logic              load;
  logic              is_lit;
  logic [WORD_W-1:0] sreg;
  logic [CNT_W-1:0]  slot;
  logic [OP_W-1:0]   op_dec;
  logic [WORD_W-1:0] payload;

  slotunp_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_q (rst_n_q)
  );

  slotunp_tap #(
    .SLOTS    (SLOTS),
    .OP_W     (OP_W),
    .INV_MASK (INV_MASK),
    .LIT_OP   (LIT_OP)
  ) u_tap (
    .sreg_i    (sreg),
    .slot_i    (slot),
    .op_o      (op_dec),
    .is_lit_o  (is_lit),
    .payload_o (payload)
  );

  slotunp_seq #(
    .SLOTS (SLOTS),
    .OP_W  (OP_W)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n_q),
    .load_i   (load),
    .word_i   (word_data),
    .step_i   (step),
    .finish_i (finish),
    .sreg_o   (sreg),
    .slot_o   (slot),
    .busy_o   (busy)
  );

  always_comb begin
    step       = busy & ~hold;
    finish     = is_lit | (slot == LAST_SLOT);
    word_ready = ~busy | (step & finish);
    load       = word_valid & word_ready;
    op_valid   = step;
    op_code    = op_dec;
    op_slot    = slot;
    lit_valid  = step & is_lit;
    lit_data   = payload;
  end

endmodule

// File: rtl/ilv_slot_unpacker_chk.sv
module ilv_slot_unpacker_chk #(
  parameter int              OP_W   = 5,
  parameter int              CNT_W  = 2,
  parameter logic [OP_W-1:0] LIT_OP = 5'd9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             hold,
  input logic             word_valid,
  input logic             word_ready,
  input logic             op_valid,
  input logic [OP_W-1:0]  op_code,
  input logic             lit_valid,
  input logic             busy,
  input logic [CNT_W-1:0] slot
);

  a_r9_lit_needs_op: assert property (@(posedge clk) disable iff (!rst_n)
    lit_valid |-> (op_valid && op_code == LIT_OP));

  a_r5_hold_silences: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> !op_valid);

  a_r5_hold_keeps_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && hold) |=> (busy && $stable(slot)));

  a_r4_slot_advances: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !word_ready) |=> (busy && slot == $past(slot) + CNT_W'(1)));

  a_r7_ready_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> word_ready);

  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!op_valid && !lit_valid));

  a_r2_load_starts_slot0: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && word_ready) |=> (busy && slot == '0));

  a_r6_literal_ends_word: assert property (@(posedge clk) disable iff (!rst_n)
    (lit_valid && !word_valid) |=> !busy);

endmodule

bind ilv_slot_unpacker ilv_slot_unpacker_chk #(
  .OP_W   (OP_W),
  .CNT_W  (CNT_W),
  .LIT_OP (LIT_OP)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n_q),
  .hold       (hold),
  .word_valid (word_valid),
  .word_ready (word_ready),
  .op_valid   (op_valid),
  .op_code    (op_code),
  .lit_valid  (lit_valid),
  .busy       (busy),
  .slot       (slot)
);

// File: tb/test_ilv_slot_unpacker.sv
module test_ilv_slot_unpacker;

  localparam int          CLK_PERIOD = 10;
  localparam int          MAX_CYCLES = 200000;
  localparam logic [19:0] MASK       = 20'hAAAAA;
  localparam logic [4:0]  LIT        = 5'd9;
  localparam int          N_WORDS    = 160;

  logic        clk;
  logic        rst_n;
  logic        word_valid;
  logic [19:0] word_data;
  logic        word_ready;
  logic        hold;
  logic        op_valid;
  logic [4:0]  op_code;
  logic [1:0]  op_slot;
  logic        lit_valid;
  logic [19:0] lit_data;

  int n_cmp;
  int n_bad;
  int cycles;
  bit done;

  ilv_slot_unpacker i_ilv_slot_unpacker (
    .clk        (clk),
    .rst_n      (rst_n),
    .word_valid (word_valid),
    .word_data  (word_data),
    .word_ready (word_ready),
    .hold       (hold),
    .op_valid   (op_valid),
    .op_code    (op_code),
    .op_slot    (op_slot),
    .lit_valid  (lit_valid),
    .lit_data   (lit_data)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > MAX_CYCLES && !done) begin
      done = 1'b1;
      check(1'b0, "watchdog", 32'(cycles), 32'(MAX_CYCLES));
      summary();
    end
  end

  // Pack four opcodes into the interleaved, partly complemented word (R3).
  function automatic logic [19:0] enc(input logic [19:0] ops);
    logic [19:0] w;
    for (int k = 0; k < 4; k++)
      for (int j = 0; j < 5; j++)
        w[4*j+k] = ops[5*k+j] ^ MASK[4*j+k];
    return w;
  endfunction

  function automatic logic [4:0] filler(input int idx, input int m);
    logic [4:0] v;
    v = 5'((idx * 7 + m * 11 + 3) % 32);
    if (v == LIT) v = v ^ 5'd1;
    return v;
  endfunction

  // Words 0..127: every value in every slot; 128..159: literal in each slot.
  function automatic logic [19:0] word_ops(input int idx);
    logic [19:0] ops;
    int k;
    for (int m = 0; m < 4; m++) ops[5*m+:5] = filler(idx, m);
    if (idx < 128) begin
      k = idx / 32;
      ops[5*k+:5] = 5'(idx % 32);
    end else begin
      k = (idx - 128) % 4;
      ops[5*k+:5] = LIT;
    end
    // Slots before the chosen one must not be literal; filler already avoids it.
    return ops;
  endfunction

  task automatic load(input logic [19:0] ops);
    #1;
    check(word_ready == 1'b1, "R2 ready before load", 32'(word_ready), 32'd1);
    word_valid = 1'b1;
    word_data  = enc(ops);
    @(negedge clk);
    word_valid = 1'b0;
  endtask

  task automatic play(input logic [19:0] ops, input int hold_at, input bit chain, input logic [19:0] nxt);
    int          last;
    bit          lit;
    logic [19:0] w;
    last = 3;
    lit  = 1'b0;
    for (int k = 3; k >= 0; k--)
      if (ops[5*k+:5] == LIT) begin
        last = k;
        lit  = 1'b1;
      end
    w = enc(ops);
    for (int k = 0; k <= last; k++) begin
      if (k == hold_at) begin
        hold = 1'b1;
        #1;
        check(op_valid == 1'b0, "R5 hold blocks op", 32'(op_valid), 32'd0);
        check(word_ready == 1'b0, "R7 no ready in hold", 32'(word_ready), 32'd0);
        @(negedge clk);
        check(op_valid == 1'b0, "R5 hold second cycle", 32'(op_valid), 32'd0);
        hold = 1'b0;
      end
      #1;
      check(op_valid == 1'b1, (k == 0) ? "R2 first slot valid" : "R4 slot valid", 32'(op_valid), 32'd1);
      check(op_slot == 2'(k), (k == 0) ? "R2 slot 0 index" : "R4 slot index", 32'(op_slot), 32'(k));
      check(op_code == ops[5*k+:5], "R3 opcode", 32'(op_code), 32'(ops[5*k+:5]));
      check(word_ready == (k == last), "R7 ready timing", 32'(word_ready), 32'(k == last));
      check(lit_valid == (lit && k == last), "R6 R9 literal strobe", 32'(lit_valid), 32'(lit && k == last));
      if (lit && k == last)
        check(lit_data == (w >> (k + 1)), "R6 literal payload", 32'(lit_data), 32'(w >> (k + 1)));
      if (k == last && chain) begin
        word_valid = 1'b1;
        word_data  = enc(nxt);
      end
      @(negedge clk);
      word_valid = 1'b0;
    end
    if (!chain) begin
      #1;
      check(op_valid == 1'b0, "R8 quiet after word", 32'(op_valid), 32'd0);
      check(lit_valid == 1'b0, "R8 no literal after word", 32'(lit_valid), 32'd0);
      check(word_ready == 1'b1, "R7 ready when idle", 32'(word_ready), 32'd1);
      @(negedge clk);
      check(op_valid == 1'b0, "R8 still quiet", 32'(op_valid), 32'd0);
    end
  endtask

  initial begin
    n_cmp      = 0;
    n_bad      = 0;
    cycles     = 0;
    done       = 1'b0;
    rst_n      = 1'b0;
    word_valid = 1'b0;
    word_data  = '0;
    hold       = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    check(op_valid == 1'b0, "R1 op_valid in reset", 32'(op_valid), 32'd0);
    check(lit_valid == 1'b0, "R1 lit_valid in reset", 32'(lit_valid), 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    check(op_valid == 1'b0, "R1 op_valid after reset", 32'(op_valid), 32'd0);
    check(lit_valid == 1'b0, "R1 lit_valid after reset", 32'(lit_valid), 32'd0);
    check(word_ready == 1'b1, "R1 ready after reset", 32'(word_ready), 32'd1);
    @(negedge clk);

    load(word_ops(0));
    for (int i = 0; i < N_WORDS; i++) begin
      bit chain;
      int hold_at;
      chain   = (i < N_WORDS - 1) && (i % 3 != 0);
      hold_at = (i % 5 == 0) ? (i / 5) % 4 : -1;
      play(word_ops(i), hold_at, chain, (i < N_WORDS - 1) ? word_ops(i + 1) : '0);
      if (!chain && i < N_WORDS - 1) load(word_ops(i + 1));
    end

    done = 1'b1;
    summary();
  end

endmodule